// File: doc/BRIEF.md
# Two-Stage Baud Tick Generator

This block derives the two timing strobes a serial port needs from the system clock. The first stage counts periods of a source enable, and that enable may be the system clock itself or the clock slowed by a fixed factor of eight. Every N source periods it emits a bit-sample tick, where N is a programmable 16-bit value. The second stage counts those sample ticks and emits one baud tick every (M+1) of them, where M is a programmable 8-bit value.

Both divider values are held in the block and are loaded through two write strobes that share one data bus. A sample divider of zero stops the generator. A baud divider write of a value below four is discarded. Any write that is accepted restarts all the counters, so the first tick after a change of rate always comes a full new period after the write. Both ticks are single-cycle pulses in the system clock domain.

Top module: `baud_tick_gen`

## Requirements
- R1: Out of reset the sample divider holds 0x028B (651) and the baud divider holds 0x0F (15), so with clk_sel low the baud ticks are 16 x 651 = 10416 cycles apart and both tick outputs are low while reset is held.
- R2: With clk_sel low and a sample divider N of 1 or more, sample_tick pulses once every N clock cycles. With N = 1 it is high on every cycle.
- R3: baud_tick pulses once for every (M+1) sample ticks, where M is the baud divider, and is high exactly one cycle after a cycle in which sample_tick was high.
- R4: A sample divider of 0 stops the generator. Neither tick is produced and both counters stay at zero until a non-zero value is written.
- R5: A baud divider write takes wr_data[7:0]. A value from 4 to 255 is stored. A value from 0 to 3 is dropped: the old divider is kept and the counters are not restarted.
- R6: With clk_sel high the source enable is the clock divided by 8 by an internal counter, so sample_tick is 8 x N cycles apart and baud_tick is 8 x N x (M+1) cycles apart.
- R7: An accepted write to either divider restarts the prescaler and both counters. If a write is sampled at clock edge E0 with clk_sel low, the first sample_tick is high after edge E0+N and the first baud_tick is high after edge E0+(M+1)xN+1.
- R8: Each tick is a one-cycle pulse: a baud tick is never followed by a baud tick on the next cycle, and for N of 2 or more the same holds for sample_tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_sel | input | 1 | 0: count every clock; 1: count the clock divided by 8 |
| wr_sample | input | 1 | Write strobe for the 16-bit sample divider |
| wr_baud | input | 1 | Write strobe for the 8-bit baud divider |
| wr_data | input | 16 | Write data; the baud divider uses bits [7:0] |
| sample_tick | output | 1 | One-cycle bit-sample strobe |
| baud_tick | output | 1 | One-cycle baud strobe |

## Verification
The assertions assume that at most one write strobe is high in any cycle and that clk_sel changes only when a write follows, so that the prescaler phase is defined by a restart. The stimulus follows this rule: it sets clk_sel before each pair of divider writes and pulses every strobe alone for a single cycle. The bench measures the spacing between ticks and their latency from a write against periods computed from the divider values. A monitor skips only the first tick after each restart.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
    localparam int SDIV_W     = 16;
    localparam int BDIV_W     = 8;
    localparam int PRE_DIV    = 8;
    localparam int SDIV_RESET = 16'h028B;
    localparam int BDIV_RESET = 8'h0F;
    localparam int BDIV_MIN   = 4;
endpackage

// File: rtl/bg_prescaler.sv
module bg_prescaler #(
    parameter int PRE_DIV = baud_gen_pkg::PRE_DIV
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic sel,
    output logic src_en
);
    localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;

    assign src_en = sel ? (st_q.cnt == LAST) : 1'b1;

    always_comb begin
        st_d = st_q;
        if (restart || !sel || st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: in divided mode an enable is never followed at once by another
    assert_prediv_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && src_en) |=> (!src_en || !sel));
endmodule

// File: rtl/bg_sample_stage.sv
module bg_sample_stage #(
    parameter int W         = baud_gen_pkg::SDIV_W,
    parameter int RESET_VAL = baud_gen_pkg::SDIV_RESET
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    input  logic         restart,
    input  logic         src_en,
    output logic         tick
);
    typedef struct packed {
        logic [W-1:0] div;
        logic [W-1:0] cnt;
        logic         tick;
    } samp_state_t;

    localparam samp_state_t RST = '{div: W'(RESET_VAL), cnt: '0, tick: 1'b0};

    samp_state_t st_d, st_q;

    assign tick = st_q.tick;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (wr_en) st_d.div = wr_val;
        if (restart || st_q.div == '0) begin
            st_d.cnt = '0;
        end else if (src_en) begin
            if (st_q.cnt == st_q.div - 1'b1) begin
                st_d.cnt  = '0;
                st_d.tick = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST;
        else        st_q <= st_d;
    end

    // R2: the running count always stays below a non-zero divider
    assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.div != '0) |-> (st_q.cnt < st_q.div));
    // R4: a zero divider keeps the counter parked and produces no tick
    assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.div == '0 && !wr_en) |=> (!tick && st_q.cnt == '0));
endmodule

// File: rtl/bg_baud_stage.sv
module bg_baud_stage #(
    parameter int W         = baud_gen_pkg::BDIV_W,
    parameter int RESET_VAL = baud_gen_pkg::BDIV_RESET,
    parameter int MIN_VAL   = baud_gen_pkg::BDIV_MIN
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    input  logic         restart,
    input  logic         sample_tick,
    output logic         accept,
    output logic         tick
);
    typedef struct packed {
        logic [W-1:0] div;
        logic [W-1:0] cnt;
        logic         tick;
    } baud_state_t;

    localparam baud_state_t RST = '{div: W'(RESET_VAL), cnt: '0, tick: 1'b0};

    baud_state_t st_d, st_q;

    assign accept = wr_en && (wr_val >= W'(MIN_VAL));
    assign tick   = st_q.tick;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (accept) st_d.div = wr_val;
        if (restart) begin
            st_d.cnt = '0;
        end else if (sample_tick) begin
            if (st_q.cnt == st_q.div) begin
                st_d.cnt  = '0;
                st_d.tick = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST;
        else        st_q <= st_d;
    end

    // R5: a write below the floor leaves the stored divider untouched
    assert_low_write_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_val < W'(MIN_VAL)) |=> $stable(st_q.div));
    // R8: baud ticks are single-cycle pulses
    assert_baud_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
    parameter int SDIV_W     = baud_gen_pkg::SDIV_W,
    parameter int BDIV_W     = baud_gen_pkg::BDIV_W,
    parameter int PRE_DIV    = baud_gen_pkg::PRE_DIV,
    parameter int SDIV_RESET = baud_gen_pkg::SDIV_RESET,
    parameter int BDIV_RESET = baud_gen_pkg::BDIV_RESET,
    parameter int BDIV_MIN   = baud_gen_pkg::BDIV_MIN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_sel,
    input  logic              wr_sample,
    input  logic              wr_baud,
    input  logic [SDIV_W-1:0] wr_data,
    output logic              sample_tick,
    output logic              baud_tick
);
    logic src_en;
    logic baud_accept;
    logic restart;

    assign restart = wr_sample || baud_accept;

    bg_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(restart),
        .sel    (clk_sel),
        .src_en (src_en)
    );

    bg_sample_stage #(.W(SDIV_W), .RESET_VAL(SDIV_RESET)) u_samp (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_sample),
        .wr_val (wr_data),
        .restart(restart),
        .src_en (src_en),
        .tick   (sample_tick)
    );

    bg_baud_stage #(.W(BDIV_W), .RESET_VAL(BDIV_RESET), .MIN_VAL(BDIV_MIN)) u_baud (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_baud),
        .wr_val     (wr_data[BDIV_W-1:0]),
        .restart    (restart),
        .sample_tick(sample_tick),
        .accept     (baud_accept),
        .tick       (baud_tick)
    );

    // R3: every baud tick follows a sample tick by one cycle
    assert_baud_after_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> $past(sample_tick));
    // R7: an accepted write clears both strobes on the next cycle
    assert_restart_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!sample_tick && !baud_tick));
endmodule

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_sel = 1'b0;
    logic        wr_sample = 1'b0;
    logic        wr_baud = 1'b0;
    logic [15:0] wr_data = '0;
    logic        sample_tick, baud_tick;

    always #5 clk = ~clk;

    baud_tick_gen uut (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel),
        .wr_sample(wr_sample), .wr_baud(wr_baud), .wr_data(wr_data),
        .sample_tick(sample_tick), .baud_tick(baud_tick)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int exp_baud[$];
    int exp_samp[$];
    string tag_baud = "R3";
    string tag_samp = "R2";
    bit skip_b = 1'b1;
    bit skip_s = 1'b1;
    int last_b = 0;
    int last_s = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: measures tick spacing and compares against queued expectations
    always @(negedge clk) begin
        cyc++;
        if (rst_n && sample_tick) begin
            if (skip_s) skip_s = 1'b0;
            else if (exp_samp.size() > 0) begin
                int e;
                e = exp_samp.pop_front();
                check(cyc - last_s == e, tag_samp, cyc - last_s, e);
            end
            last_s = cyc;
        end
        if (rst_n && baud_tick) begin
            if (skip_b) skip_b = 1'b0;
            else if (exp_baud.size() > 0) begin
                int e;
                e = exp_baud.pop_front();
                check(cyc - last_b == e, tag_baud, cyc - last_b, e);
            end
            last_b = cyc;
        end
    end

    task automatic wr_s(input int v);
        wr_data = 16'(v); wr_sample = 1'b1;
        @(negedge clk);
        wr_sample = 1'b0;
    endtask

    task automatic wr_b(input int v);
        wr_data = 16'(v); wr_baud = 1'b1;
        @(negedge clk);
        wr_baud = 1'b0;
    endtask

    // driver: pushes expected periods, then waits for the monitor to drain them
    task automatic expect_periods(input int n, input int sp, input int bp,
                                  input string ts, input string tb);
        exp_samp.delete(); exp_baud.delete();
        tag_samp = ts; tag_baud = tb;
        skip_s = 1'b1; skip_b = 1'b1;
        for (int i = 0; i < n; i++) begin
            exp_samp.push_back(sp);
            exp_baud.push_back(bp);
        end
        while (exp_baud.size() != 0) @(negedge clk);
    endtask

    task automatic config_run(input int d, input int b, input bit sel, input int n,
                              input string ts, input string tb);
        @(negedge clk);
        clk_sel = sel;
        wr_s(d);
        wr_b(b);
        expect_periods(n, d * (sel ? 8 : 1), d * (b + 1) * (sel ? 8 : 1), ts, tb);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(sample_tick == 0 && baud_tick == 0, "R1 reset outputs", sample_tick + baud_tick, 0);
        rst_n = 1'b1;
        // R1: default dividers give 651-cycle samples and 10416-cycle baud
        expect_periods(1, 651, 10416, "R1 default sample", "R1 default baud");

        // R2 R3: normal mode, small dividers
        config_run(3, 4, 1'b0, 3, "R2 sample D3", "R3 baud D3 M4");
        config_run(1, 4, 1'b0, 2, "R2 sample D1", "R3 baud D1 M4");
        config_run(5, 9, 1'b0, 2, "R2 sample D5", "R3 baud D5 M9");

        // R6: divided clock source
        config_run(2, 5, 1'b1, 2, "R6 sample sel1", "R6 baud sel1");

        // R5: low writes dropped, old divider kept
        config_run(2, 6, 1'b0, 1, "R5 setup", "R5 setup");
        wr_b(3);
        expect_periods(2, 2, 14, "R5 after write 3", "R5 after write 3");
        wr_b(0);
        expect_periods(1, 2, 14, "R5 after write 0", "R5 after write 0");
        wr_b(4);
        expect_periods(2, 2, 10, "R5 write 4 taken", "R5 write 4 taken");

        // R4: zero divider stops all ticks
        begin
            int cnt_s = 0;
            int cnt_b = 0;
            wr_s(0);
            for (int i = 0; i < 300; i++) begin
                @(negedge clk);
                cnt_s += sample_tick;
                cnt_b += baud_tick;
            end
            check(cnt_s == 0, "R4 no sample tick", cnt_s, 0);
            check(cnt_b == 0, "R4 no baud tick", cnt_b, 0);
        end
        wr_s(5);
        expect_periods(2, 5, 25, "R4 resume sample", "R4 resume baud");

        // R7 R8: latency after a write and pulse width
        begin
            int lat = 0;
            int ls = -1;
            int lb = -1;
            bit wide_s = 1'b0;
            bit wide_b = 1'b0;
            bit prev_s = 1'b0;
            bit prev_b = 1'b0;
            repeat (3) @(negedge clk);
            wr_data = 16'd7; wr_sample = 1'b1;
            @(negedge clk);
            wr_sample = 1'b0;
            lat = 1;
            while (lb < 0 && lat < 200) begin
                @(negedge clk);
                lat++;
                if (sample_tick && ls < 0) ls = lat;
                if (baud_tick && lb < 0) lb = lat;
                if (sample_tick && prev_s) wide_s = 1'b1;
                if (baud_tick && prev_b) wide_b = 1'b1;
                prev_s = sample_tick;
                prev_b = baud_tick;
            end
            check(ls == 8, "R7 first sample latency", ls, 8);
            check(lb == 37, "R7 first baud latency", lb, 37);
            @(negedge clk);
            if (baud_tick) wide_b = 1'b1;
            check(!wide_s, "R8 sample pulse width", wide_s, 0);
            check(!wide_b, "R8 baud pulse width", wide_b, 0);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule